// File: doc/BRIEF.md
# Doorbell Mailbox Register File

This block is the hardware meeting point between a host processor and an embedded service engine. The host places a four-word command into a command bank and rings the engine's doorbell. The engine reads the command, acknowledges it, and later places a four-word reply into a separate reply bank and rings the host's doorbell. Each doorbell drives a level interrupt toward its reader. The interrupt stays high while any doorbell bit is set, and it drops once the reader has cleared every bit.

Each side has its own simple register port. Reads are combinational and writes take effect at the clock edge. Every doorbell can be reached through three aliases. One replaces the whole value, one sets the bits written as one, and one clears the bits written as zero. Software can therefore raise or retire single events without a read-modify-write. A guard allows only one command in flight. From the moment the host announces a command until the engine posts a reply or reports that it has come back from reset, further host writes to the command bank are dropped and a sticky error flag is raised.

Top module: `mbx_regfile`

Word address map (4-bit word address, the same on both ports): 0–3 command words 0–3; 4 engine doorbell replace, 5 engine doorbell set, 6 engine doorbell clear; 8–11 reply words 0–3; 12 host doorbell replace, 13 host doorbell set, 14 host doorbell clear; 7 and 15 are unmapped. Every doorbell alias reads back the current doorbell value, zero-extended.

## Requirements
- R1: After reset every command word, reply word and doorbell reads zero, and `h_irq`, `e_irq`, `cmd_busy` and `proto_err` are low.
- R2: A host write to word address 0–3 stores the full 64-bit word, and both ports read it back. An engine write to addresses 0–3 leaves the command bank unchanged.
- R3: An engine write to word address 8–11 stores the full word, and both ports read it back. A host write to addresses 8–11 leaves the reply bank unchanged.
- R4: A write to the replace alias (4 or 12) sets that doorbell to the low doorbell bits of the write data. Reading any of that doorbell's three aliases returns the current value.
- R5: A write to the set alias (5 or 13) sets every doorbell bit written as 1 and leaves the other bits unchanged.
- R6: A write to the clear alias (6 or 14) clears every doorbell bit written as 0 and leaves the bits written as 1 unchanged.
- R7: `e_irq` is high exactly while the engine doorbell is nonzero, and `h_irq` is high exactly while the host doorbell is nonzero. Each follows its doorbell from the same clock edge.
- R8: Bit 0 of the engine doorbell means "command waiting". The host doorbell bits mean: bit 0 command read, bit 1 reply waiting, bit 2 engine back from reset, bit 3 passthrough request. `cmd_busy` rises after a host write of bit 0 through the engine doorbell's replace or set alias. It falls after an engine write through the host doorbell's replace or set alias that carries bit 1 or bit 2. Bit 0 alone does not release it.
- R9: While `cmd_busy` is high, a host write to the command bank is dropped and `proto_err` goes high. `proto_err` then stays high until reset.
- R10: When one port sets a doorbell bit and the other port clears the same bit in the same cycle, the bit ends up set.
- R11: Word addresses 7 and 15 read as zero, and writes to them change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| h_req | input | 1 | Host port access strobe |
| h_we | input | 1 | Host port write enable |
| h_addr | input | 4 | Host port word address |
| h_wdata | input | 64 | Host port write data |
| h_rdata | output | 64 | Host port read data (combinational) |
| e_req | input | 1 | Engine port access strobe |
| e_we | input | 1 | Engine port write enable |
| e_addr | input | 4 | Engine port word address |
| e_wdata | input | 64 | Engine port write data |
| e_rdata | output | 64 | Engine port read data (combinational) |
| h_irq | output | 1 | Level interrupt to host, host doorbell nonzero |
| e_irq | output | 1 | Level interrupt to engine, engine doorbell nonzero |
| cmd_busy | output | 1 | A command is in flight |
| proto_err | output | 1 | Sticky: command bank written while busy |

## Verification
The assertions assume that both ports hold their strobe, write enable, address and data stable across each sampling edge, and that reset is held high from time zero until the first checked edge. The bench drives every port only on the falling clock edge and keeps reset high for several cycles before any access. Same-cycle collisions on a doorbell are produced only by a dedicated task that drives both ports in the same falling-edge slot. The bench never relies on a particular ordering between ports for anything other than the set-over-clear rule.

// File: rtl/mbx_pkg.sv
package mbx_pkg;

    localparam int ADDR_W    = 4;
    localparam int NUM_WORDS = 4;
    localparam int WIDX_W    = $clog2(NUM_WORDS);

    // engine doorbell bit
    localparam int EDB_CMD_BIT   = 0;
    // host doorbell bits
    localparam int HDB_ACK_BIT   = 0;
    localparam int HDB_REPLY_BIT = 1;
    localparam int HDB_RESET_BIT = 2;
    localparam int HDB_PASS_BIT  = 3;

    typedef enum logic [1:0] {
        DB_NONE = 2'd0,
        DB_RW   = 2'd1,
        DB_OR   = 2'd2,
        DB_AND  = 2'd3
    } db_op_e;

    typedef struct packed {
        logic              is_cmd;
        logic              is_rpl;
        logic [WIDX_W-1:0] word;
        db_op_e            edb_op;
        db_op_e            hdb_op;
    } dec_t;

    function automatic db_op_e alias_op(input logic [1:0] sel);
        case (sel)
            2'd0:    return DB_RW;
            2'd1:    return DB_OR;
            2'd2:    return DB_AND;
            default: return DB_NONE;
        endcase
    endfunction

    // bit 3 picks the side, bit 2 picks words versus doorbell
    function automatic dec_t decode(input logic [ADDR_W-1:0] a);
        dec_t d;
        d.is_cmd = (a[3:2] == 2'b00);
        d.is_rpl = (a[3:2] == 2'b10);
        d.word   = a[WIDX_W-1:0];
        d.edb_op = (a[3:2] == 2'b01) ? alias_op(a[1:0]) : DB_NONE;
        d.hdb_op = (a[3:2] == 2'b11) ? alias_op(a[1:0]) : DB_NONE;
        return d;
    endfunction

    function automatic logic posts(input db_op_e op);
        return (op == DB_RW) || (op == DB_OR);
    endfunction

endpackage

// File: rtl/mbx_bank.sv
module mbx_bank #(
    parameter int DATA_W = 64,
    parameter int NUM_W  = 4,
    localparam int IDX_W = $clog2(NUM_W)
) (
    input  logic                         clk,
    input  logic                         rst,
    input  logic                         we,
    input  logic [IDX_W-1:0]             widx,
    input  logic [DATA_W-1:0]            wdata,
    output logic [NUM_W-1:0][DATA_W-1:0] q
);
    for (genvar i = 0; i < NUM_W; i++) begin : g_word
        always_ff @(posedge clk) begin
            if (rst) begin
                q[i] <= '0;
            end else if (we && (widx == IDX_W'(i))) begin
                q[i] <= wdata;
            end
        end
    end
endmodule

// File: rtl/mbx_doorbell.sv
module mbx_doorbell
    import mbx_pkg::*;
#(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  db_op_e       a_op,
    input  logic [W-1:0] a_data,
    input  db_op_e       b_op,
    input  logic [W-1:0] b_data,
    output logic [W-1:0] q
);
    logic [W-1:0] set_a, clr_a, set_b, clr_b;

    function automatic logic [2*W-1:0] masks(input db_op_e op, input logic [W-1:0] d);
        case (op)
            DB_RW:   return {d, ~d};
            DB_OR:   return {d, {W{1'b0}}};
            DB_AND:  return {{W{1'b0}}, ~d};
            default: return '0;
        endcase
    endfunction

    always_comb begin
        {set_a, clr_a} = masks(a_op, a_data);
        {set_b, clr_b} = masks(b_op, b_data);
    end

    // set is applied after clear so that a set always wins
    always_ff @(posedge clk) begin
        if (rst) begin
            q <= '0;
        end else begin
            q <= (q & ~(clr_a | clr_b)) | set_a | set_b;
        end
    end
endmodule

// File: rtl/mbx_guard.sv
module mbx_guard (
    input  logic clk,
    input  logic rst,
    input  logic cmd_wr,
    input  logic post_cmd,
    input  logic post_done,
    output logic cmd_wr_ok,
    output logic busy,
    output logic perr
);
    assign cmd_wr_ok = cmd_wr && !busy;

    always_ff @(posedge clk) begin
        if (rst) begin
            busy <= 1'b0;
            perr <= 1'b0;
        end else begin
            if (post_cmd) begin
                busy <= 1'b1;
            end else if (post_done) begin
                busy <= 1'b0;
            end
            if (cmd_wr && busy) begin
                perr <= 1'b1;
            end
        end
    end
endmodule

// File: rtl/mbx_regfile.sv
module mbx_regfile
    import mbx_pkg::*;
#(
    parameter int DATA_W = 64,
    parameter int DB_W   = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              h_req,
    input  logic              h_we,
    input  logic [3:0]        h_addr,
    input  logic [DATA_W-1:0] h_wdata,
    output logic [DATA_W-1:0] h_rdata,
    input  logic              e_req,
    input  logic              e_we,
    input  logic [3:0]        e_addr,
    input  logic [DATA_W-1:0] e_wdata,
    output logic [DATA_W-1:0] e_rdata,
    output logic              h_irq,
    output logic              e_irq,
    output logic              cmd_busy,
    output logic              proto_err
);
    typedef logic [NUM_WORDS-1:0][DATA_W-1:0] bank_t;

    dec_t       hd, ed;
    logic       h_wr, e_wr;
    db_op_e     h_edb_op, h_hdb_op, e_edb_op, e_hdb_op;
    logic       cmd_wr, cmd_wr_ok, rpl_wr;
    logic       post_cmd, post_done;
    bank_t      cmd_q, rpl_q;
    logic [DB_W-1:0] edb_q, hdb_q;

    assign hd   = decode(h_addr);
    assign ed   = decode(e_addr);
    assign h_wr = h_req && h_we;
    assign e_wr = e_req && e_we;

    assign h_edb_op = h_wr ? hd.edb_op : DB_NONE;
    assign h_hdb_op = h_wr ? hd.hdb_op : DB_NONE;
    assign e_edb_op = e_wr ? ed.edb_op : DB_NONE;
    assign e_hdb_op = e_wr ? ed.hdb_op : DB_NONE;

    assign cmd_wr    = h_wr && hd.is_cmd;
    assign rpl_wr    = e_wr && ed.is_rpl;
    assign post_cmd  = posts(h_edb_op) && h_wdata[EDB_CMD_BIT];
    assign post_done = posts(e_hdb_op) &&
                       (e_wdata[HDB_REPLY_BIT] || e_wdata[HDB_RESET_BIT]);

    mbx_bank #(.DATA_W(DATA_W), .NUM_W(NUM_WORDS)) u_cmd_bank (
        .clk(clk), .rst(rst), .we(cmd_wr_ok), .widx(hd.word),
        .wdata(h_wdata), .q(cmd_q)
    );

    mbx_bank #(.DATA_W(DATA_W), .NUM_W(NUM_WORDS)) u_rpl_bank (
        .clk(clk), .rst(rst), .we(rpl_wr), .widx(ed.word),
        .wdata(e_wdata), .q(rpl_q)
    );

    mbx_doorbell #(.W(DB_W)) u_edb (
        .clk(clk), .rst(rst),
        .a_op(h_edb_op), .a_data(h_wdata[DB_W-1:0]),
        .b_op(e_edb_op), .b_data(e_wdata[DB_W-1:0]),
        .q(edb_q)
    );

    mbx_doorbell #(.W(DB_W)) u_hdb (
        .clk(clk), .rst(rst),
        .a_op(h_hdb_op), .a_data(h_wdata[DB_W-1:0]),
        .b_op(e_hdb_op), .b_data(e_wdata[DB_W-1:0]),
        .q(hdb_q)
    );

    mbx_guard u_guard (
        .clk(clk), .rst(rst), .cmd_wr(cmd_wr),
        .post_cmd(post_cmd), .post_done(post_done),
        .cmd_wr_ok(cmd_wr_ok), .busy(cmd_busy), .perr(proto_err)
    );

    function automatic logic [DATA_W-1:0] rd_sel(
        input dec_t d, input bank_t c, input bank_t r,
        input logic [DB_W-1:0] e, input logic [DB_W-1:0] h
    );
        logic [DATA_W-1:0] v;
        v = '0;
        if (d.is_cmd)                  v = c[d.word];
        else if (d.is_rpl)             v = r[d.word];
        else if (d.edb_op != DB_NONE)  v[DB_W-1:0] = e;
        else if (d.hdb_op != DB_NONE)  v[DB_W-1:0] = h;
        return v;
    endfunction

    assign h_rdata = rd_sel(hd, cmd_q, rpl_q, edb_q, hdb_q);
    assign e_rdata = rd_sel(ed, cmd_q, rpl_q, edb_q, hdb_q);

    assign h_irq = |hdb_q;
    assign e_irq = |edb_q;
endmodule

// File: rtl/mbx_regfile_chk.sv
module mbx_regfile_chk #(
    parameter int DATA_W = 64,
    parameter int DB_W   = 8
) (
    input logic                  clk,
    input logic                  rst,
    input logic                  h_req,
    input logic                  h_we,
    input logic [3:0]            h_addr,
    input logic [DATA_W-1:0]     h_wdata,
    input logic                  e_req,
    input logic                  e_we,
    input logic [3:0]            e_addr,
    input logic [DATA_W-1:0]     e_wdata,
    input logic                  e_irq,
    input logic                  h_irq,
    input logic                  cmd_busy,
    input logic                  proto_err,
    input logic [4*DATA_W-1:0]   cmd_q,
    input logic [DB_W-1:0]       edb_q
);
    logic h_cmd_wr, e_cmd_wr, h_edb_wr, e_edb_wr, h_post;

    assign h_cmd_wr = h_req && h_we && (h_addr[3:2] == 2'b00);
    assign e_cmd_wr = e_req && e_we && (e_addr[3:2] == 2'b00);
    assign h_edb_wr = h_req && h_we && (h_addr[3:2] == 2'b01);
    assign e_edb_wr = e_req && e_we && (e_addr[3:2] == 2'b01);
    assign h_post   = h_req && h_we && (h_addr == 4'd4 || h_addr == 4'd5) && h_wdata[0];

    // R1
    reset_clean_chk: assert property (@(posedge clk)
        rst |=> (!cmd_busy && !proto_err && !h_irq && !e_irq));

    // R9
    perr_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        proto_err |=> proto_err);

    // R9
    perr_flag_chk: assert property (@(posedge clk) disable iff (rst)
        (cmd_busy && h_cmd_wr) |=> proto_err);

    // R9
    busy_drop_chk: assert property (@(posedge clk) disable iff (rst)
        (cmd_busy && h_cmd_wr) |=> $stable(cmd_q));

    // R2
    eng_cmd_ignored_chk: assert property (@(posedge clk) disable iff (rst)
        (e_cmd_wr && !h_cmd_wr) |=> $stable(cmd_q));

    // R8
    busy_set_chk: assert property (@(posedge clk) disable iff (rst)
        h_post |=> cmd_busy);

    // R5
    or_sets_chk: assert property (@(posedge clk) disable iff (rst)
        (e_req && e_we && e_addr == 4'd5) |=>
        ((edb_q & $past(e_wdata[DB_W-1:0])) == $past(e_wdata[DB_W-1:0])));

    // R7
    eirq_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        (!e_irq && !h_edb_wr && !e_edb_wr) |=> !e_irq);
endmodule

bind mbx_regfile mbx_regfile_chk #(.DATA_W(DATA_W), .DB_W(DB_W)) u_chk (
    .clk(clk), .rst(rst),
    .h_req(h_req), .h_we(h_we), .h_addr(h_addr), .h_wdata(h_wdata),
    .e_req(e_req), .e_we(e_we), .e_addr(e_addr), .e_wdata(e_wdata),
    .e_irq(e_irq), .h_irq(h_irq), .cmd_busy(cmd_busy), .proto_err(proto_err),
    .cmd_q(cmd_q), .edb_q(edb_q)
);

// File: tb/mbx_regfile_tb.sv
module mbx_regfile_tb;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        h_req = 0, h_we = 0, e_req = 0, e_we = 0;
    logic [3:0]  h_addr = 0, e_addr = 0;
    logic [63:0] h_wdata = 0, e_wdata = 0;
    logic [63:0] h_rdata, e_rdata;
    logic        h_irq, e_irq, cmd_busy, proto_err;

    int total = 0;
    int bad   = 0;
    logic done = 1'b0;

    always #5 clk = ~clk;

    mbx_regfile u_dut (
        .clk(clk), .rst(rst),
        .h_req(h_req), .h_we(h_we), .h_addr(h_addr), .h_wdata(h_wdata), .h_rdata(h_rdata),
        .e_req(e_req), .e_we(e_we), .e_addr(e_addr), .e_wdata(e_wdata), .e_rdata(e_rdata),
        .h_irq(h_irq), .e_irq(e_irq), .cmd_busy(cmd_busy), .proto_err(proto_err)
    );

    task automatic chk(input string req, input logic [63:0] got, input logic [63:0] exp);
        total++;
        if (got !== exp) begin
            bad++;
            $display("FAIL %s: got %h expected %h", req, got, exp);
        end
    endtask

    task automatic hw(input logic [3:0] a, input logic [63:0] d);
        @(negedge clk); h_req = 1; h_we = 1; h_addr = a; h_wdata = d;
        @(negedge clk); h_req = 0; h_we = 0;
    endtask

    task automatic ew(input logic [3:0] a, input logic [63:0] d);
        @(negedge clk); e_req = 1; e_we = 1; e_addr = a; e_wdata = d;
        @(negedge clk); e_req = 0; e_we = 0;
    endtask

    task automatic both(input logic [3:0] ha, input logic [63:0] hd,
                        input logic [3:0] ea, input logic [63:0] ed);
        @(negedge clk);
        h_req = 1; h_we = 1; h_addr = ha; h_wdata = hd;
        e_req = 1; e_we = 1; e_addr = ea; e_wdata = ed;
        @(negedge clk);
        h_req = 0; h_we = 0; e_req = 0; e_we = 0;
    endtask

    task automatic hr(input logic [3:0] a, output logic [63:0] d);
        h_addr = a; #1; d = h_rdata;
    endtask

    task automatic er(input logic [3:0] a, output logic [63:0] d);
        e_addr = a; #1; d = e_rdata;
    endtask

    task automatic t_reset();
        logic [63:0] v;
        for (int a = 0; a < 16; a++) begin
            hr(4'(a), v); chk("R1 host read after reset", v, 64'h0);
        end
        chk("R1 h_irq", {63'h0, h_irq}, 64'h0);
        chk("R1 e_irq", {63'h0, e_irq}, 64'h0);
        chk("R1 cmd_busy", {63'h0, cmd_busy}, 64'h0);
        chk("R1 proto_err", {63'h0, proto_err}, 64'h0);
    endtask

    task automatic t_cmd_bank();
        logic [63:0] v;
        for (int i = 0; i < 4; i++) hw(4'(i), 64'hC0DE_0000_0000_1000 + 64'(i) * 64'h1111);
        for (int i = 0; i < 4; i++) begin
            er(4'(i), v); chk("R2 engine reads command", v, 64'hC0DE_0000_0000_1000 + 64'(i) * 64'h1111);
        end
        ew(4'd2, 64'hBAD0_BAD0_BAD0_BAD0);
        hr(4'd2, v); chk("R2 engine write to command ignored", v, 64'hC0DE_0000_0000_3222);
    endtask

    task automatic t_rpl_bank();
        logic [63:0] v;
        for (int i = 0; i < 4; i++) ew(4'(8 + i), {32'hFEED_0000 + 32'(i), 32'h8765_4321});
        for (int i = 0; i < 4; i++) begin
            hr(4'(8 + i), v); chk("R3 host reads reply", v, {32'hFEED_0000 + 32'(i), 32'h8765_4321});
        end
        hw(4'd9, 64'h0);
        er(4'd9, v); chk("R3 host write to reply ignored", v, 64'hFEED_0001_8765_4321);
    endtask

    task automatic t_doorbell();
        logic [63:0] v;
        ew(4'd4, 64'hFFFF_0000_0000_005A);
        hr(4'd4, v); chk("R4 replace alias", v, 64'h5A);
        hr(4'd5, v); chk("R4 set alias readback", v, 64'h5A);
        hr(4'd6, v); chk("R4 clear alias readback", v, 64'h5A);
        chk("R7 e_irq with nonzero doorbell", {63'h0, e_irq}, 64'h1);
        ew(4'd5, 64'h81);
        hr(4'd4, v); chk("R5 set alias", v, 64'hDB);
        ew(4'd6, 64'hF0);
        hr(4'd4, v); chk("R6 clear alias", v, 64'hD0);
        ew(4'd6, 64'h00);
        hr(4'd4, v); chk("R6 clear all", v, 64'h0);
        chk("R7 e_irq drops", {63'h0, e_irq}, 64'h0);
        hw(4'd12, 64'h08);
        chk("R7 h_irq rises", {63'h0, h_irq}, 64'h1);
        hw(4'd14, 64'h00);
        chk("R7 h_irq drops", {63'h0, h_irq}, 64'h0);
        chk("R8 no busy from doorbell tests", {63'h0, cmd_busy}, 64'h0);
    endtask

    task automatic t_guard();
        logic [63:0] v;
        hw(4'd0, 64'h1111_2222_3333_4444);
        hw(4'd5, 64'h01);
        chk("R8 busy after command posted", {63'h0, cmd_busy}, 64'h1);
        chk("R7 e_irq on command", {63'h0, e_irq}, 64'h1);
        hw(4'd0, 64'h5555_6666_7777_8888);
        er(4'd0, v); chk("R9 command write dropped while busy", v, 64'h1111_2222_3333_4444);
        chk("R9 proto_err raised", {63'h0, proto_err}, 64'h1);
        ew(4'd6, 64'h00);
        ew(4'd13, 64'h01);
        chk("R8 ack alone keeps busy", {63'h0, cmd_busy}, 64'h1);
        ew(4'd13, 64'h02);
        chk("R8 reply releases busy", {63'h0, cmd_busy}, 64'h0);
        chk("R7 h_irq on reply", {63'h0, h_irq}, 64'h1);
        hw(4'd0, 64'h5555_6666_7777_8888);
        er(4'd0, v); chk("R2 command write after release", v, 64'h5555_6666_7777_8888);
        chk("R9 proto_err sticky", {63'h0, proto_err}, 64'h1);
        hw(4'd4, 64'h01);
        chk("R8 busy via replace alias", {63'h0, cmd_busy}, 64'h1);
        ew(4'd13, 64'h04);
        chk("R8 reset notice releases busy", {63'h0, cmd_busy}, 64'h0);
    endtask

    task automatic t_race();
        logic [63:0] v;
        ew(4'd4, 64'h0);
        both(4'd6, 64'h00, 4'd5, 64'h01);
        hr(4'd4, v); chk("R10 engine set beats host clear", v, 64'h01);
        both(4'd5, 64'h02, 4'd6, 64'h00);
        hr(4'd4, v); chk("R10 host set beats engine clear", v, 64'h02);
        both(4'd12, 64'h00, 4'd13, 64'h08);
        hr(4'd12, v); chk("R10 set beats replace", v, 64'h08);
        chk("R8 passthrough leaves busy low", {63'h0, cmd_busy}, 64'h0);
    endtask

    task automatic t_unmapped();
        logic [63:0] v;
        hw(4'd15, '1);
        ew(4'd7, '1);
        hr(4'd15, v); chk("R11 addr 15 reads zero", v, 64'h0);
        er(4'd7, v);  chk("R11 addr 7 reads zero", v, 64'h0);
        hr(4'd12, v); chk("R11 host doorbell untouched", v, 64'h08);
        hr(4'd4, v);  chk("R11 engine doorbell untouched", v, 64'h02);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst = 0;
        @(negedge clk);
        t_reset();
        t_cmd_bank();
        t_rpl_bank();
        t_doorbell();
        t_guard();
        t_race();
        t_unmapped();
        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog: got hung expected finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule